// File: doc/BRIEF.md
# Maskable I/O Address Window Decoder

This block decides whether an incoming 16-bit I/O-cycle address falls inside a programmable window. Software programs a 16-bit base address as two byte registers. It also programs a mask byte whose set bits turn the matching low-order address bits into don't-care positions. Address bits 15..8 have no mask bits, so the upper byte of the address must always equal the upper base byte. The hit output is combinational and is qualified by an I/O-cycle valid input.

A small indexed register file holds the configuration. Software selects a register with an index, writes on a strobe and reads through a combinational data port. The same file holds a clock-output disable bit. The block turns this bit into an active-high enable for an external clock gate. Reset is synchronous and active low. After reset the mask is all ones and the base is zero, so the window covers 0x0000 to 0x00FF.

Top module: `io_window_decoder`

## Requirements
- R1: After reset, index 0x3F (mask) reads 0xFF, indices 0x40 and 0x41 (base low and high bytes) read 0x00, index 0x50 (control) reads 0x00, and `clk_out_en` is 1.
- R2: A write with `cfg_we` high takes effect at the next rising clock edge. From that edge on, reading index 0x3F, 0x40 or 0x41 returns exactly the byte last written to it.
- R3: At index 0x50 only bit 0 is stored. Bits 7..1 always read as zero, whatever was written to them.
- R4: `clk_out_en` is the inverse of control bit 0: writing 1 to index 0x50 bit 0 drives it to 0, and writing 0 drives it back to 1.
- R5: Reading any index other than 0x3F, 0x40, 0x41 and 0x50 returns 0x00. A write to such an index changes no register, no readback value, no hit result and not `clk_out_en`.
- R6: When `io_valid` is 1, `io_hit` is 1 exactly when `io_addr[15:8]` equals the base high byte and every bit `io_addr[i]` (i in 0..7) whose mask bit is 0 equals base bit i. The base is {index 0x41, index 0x40}.
- R7: A mask bit set to 1 makes the matching address bit among 7..0 a don't-care. With base 0x0000 and mask 0xFF, every address from 0x0000 to 0x00FF hits and 0x0100 misses.
- R8: The high address byte is never masked. A difference in any of bits 15..8 gives a miss even when the mask is 0xFF.
- R9: When `io_valid` is 0, `io_hit` is 0 whatever the address.
- R10: `io_hit` follows `io_addr` and `io_valid` in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 8 | Register index for reads and writes |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Combinational read data for `cfg_idx` |
| io_valid | input | 1 | Qualifies `io_addr` as a live I/O cycle |
| io_addr | input | 16 | I/O cycle address |
| io_hit | output | 1 | Address falls inside the programmed window |
| clk_out_en | output | 1 | Enable for the external clock gate |

## Verification
The bench probes the window at the edges of the mask. It uses addresses that differ from the base only in a masked bit, only in an unmasked low bit, and only in a high-byte bit with the mask fully open. A decoder that let the mask reach bits 15..8, or that inverted the mask sense, would pass or reject the wrong ones. The bench writes ones into the reserved control bits and writes to indices next to the implemented ones (0x3E, 0x42, 0x51). A decoder with a loose index compare would then corrupt a register or return stale data. It also holds a matching address while `io_valid` is low, and flips the clock-disable bit both ways.

// File: rtl/io_win_pkg.sv
// Package: shared widths and the configuration bundle for the I/O window decoder.
// Assumes byte-wide registers and an address that is a whole number of bytes.
package io_win_pkg;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned IDX_W      = 8;
    localparam int unsigned ADDR_W     = 16;
    localparam int unsigned MASK_W     = 8;
    localparam int unsigned BASE_BYTES = ADDR_W / DATA_W;

    typedef struct packed {
        logic [MASK_W-1:0] mask;     // 1 = address bit is don't-care
        logic [ADDR_W-1:0] base;     // window base address
        logic              clk_off;  // 1 = clock output disabled
    } io_win_cfg_t;
endpackage

// File: rtl/io_win_regs.sv
// Module: configuration register storage.
// Holds the mask, the base bytes and the clock-disable bit. Each register is written on
// cfg_we when cfg_idx equals its index. Reset is synchronous and active low. Assumes the
// base bytes occupy consecutive indices starting at IDX_BASE_LO.
module io_win_regs
    import io_win_pkg::*;
#(
    parameter logic [IDX_W-1:0] IDX_MASK    = 8'h3F,
    parameter logic [IDX_W-1:0] IDX_BASE_LO = 8'h40,
    parameter logic [IDX_W-1:0] IDX_CTRL    = 8'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output io_win_cfg_t       cfg
);
    // Mask register: resets to all don't-care.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg.mask <= '1;
        else if (we && idx == IDX_MASK)
            cfg.mask <= wdata[MASK_W-1:0];
    end

    // One byte register per base byte, at consecutive indices.
    for (genvar b = 0; b < BASE_BYTES; b++) begin : g_base
        localparam logic [IDX_W-1:0] MY_IDX = IDX_BASE_LO + IDX_W'(b);
        // Base byte b: cleared on reset, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg.base[b*DATA_W +: DATA_W] <= '0;
            else if (we && idx == MY_IDX)
                cfg.base[b*DATA_W +: DATA_W] <= wdata;
        end
    end

    // Clock-disable bit: only bit 0 of the control byte is stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg.clk_off <= 1'b0;
        else if (we && idx == IDX_CTRL)
            cfg.clk_off <= wdata[0];
    end
endmodule

// File: rtl/io_win_rdmux.sv
// Module: combinational readback multiplexer.
// Returns the selected register. Reserved control bits and unknown indices read as zero.
module io_win_rdmux
    import io_win_pkg::*;
#(
    parameter logic [IDX_W-1:0] IDX_MASK    = 8'h3F,
    parameter logic [IDX_W-1:0] IDX_BASE_LO = 8'h40,
    parameter logic [IDX_W-1:0] IDX_CTRL    = 8'h50
) (
    input  logic [IDX_W-1:0]  idx,
    input  io_win_cfg_t       cfg,
    output logic [DATA_W-1:0] rdata
);
    // Select the addressed register, default zero.
    always_comb begin
        rdata = '0;
        if (idx == IDX_MASK)
            rdata[MASK_W-1:0] = cfg.mask;
        for (int b = 0; b < BASE_BYTES; b++) begin
            if (idx == IDX_BASE_LO + IDX_W'(b))
                rdata = cfg.base[b*DATA_W +: DATA_W];
        end
        if (idx == IDX_CTRL)
            rdata[0] = cfg.clk_off;
    end
endmodule

// File: rtl/io_win_match.sv
// Module: masked address comparator.
// Bits below MASK_W are compared only where the mask bit is 0. Bits at and above MASK_W
// are always compared. Purely combinational.
module io_win_match
    import io_win_pkg::*;
(
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [MASK_W-1:0] mask,
    output logic              hit
);
    logic [ADDR_W-1:0] care;
    logic [ADDR_W-1:0] diff;

    // Build the per-bit "must match" vector; the upper bits have no mask.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_care
        if (i < MASK_W) begin : g_maskable
            assign care[i] = ~mask[i];
        end else begin : g_fixed
            assign care[i] = 1'b1;
        end
    end

    // Differing bits that matter.
    assign diff = (addr ^ base) & care;

    // Hit only on a live cycle with no relevant difference.
    assign hit = valid && (diff == '0);
endmodule

// File: rtl/io_window_decoder.sv
// Module: top of the maskable I/O address window decoder.
// Ties the register file, the readback mux and the comparator together, and drives
// the clock-gate enable. Assumes a byte-wide index/data configuration port.
module io_window_decoder
    import io_win_pkg::*;
#(
    parameter logic [IDX_W-1:0] IDX_MASK    = 8'h3F,
    parameter logic [IDX_W-1:0] IDX_BASE_LO = 8'h40,
    parameter logic [IDX_W-1:0] IDX_CTRL    = 8'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              io_valid,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              io_hit,
    output logic              clk_out_en
);
    io_win_cfg_t cfg_q;

    io_win_regs #(
        .IDX_MASK(IDX_MASK), .IDX_BASE_LO(IDX_BASE_LO), .IDX_CTRL(IDX_CTRL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
        .wdata(cfg_wdata), .cfg(cfg_q)
    );

    io_win_rdmux #(
        .IDX_MASK(IDX_MASK), .IDX_BASE_LO(IDX_BASE_LO), .IDX_CTRL(IDX_CTRL)
    ) u_rdmux (
        .idx(cfg_idx), .cfg(cfg_q), .rdata(cfg_rdata)
    );

    io_win_match u_match (
        .valid(io_valid), .addr(io_addr), .base(cfg_q.base),
        .mask(cfg_q.mask), .hit(io_hit)
    );

    // Clock gate enable is the inverse of the stored disable bit.
    assign clk_out_en = ~cfg_q.clk_off;
endmodule

// File: rtl/io_win_chk.sv
// Module: assertion checker for io_window_decoder, attached by bind.
// Watches the ports plus the stored base address.
module io_win_chk
    import io_win_pkg::*;
#(
    parameter logic [IDX_W-1:0] IDX_MASK    = 8'h3F,
    parameter logic [IDX_W-1:0] IDX_BASE_LO = 8'h40,
    parameter logic [IDX_W-1:0] IDX_CTRL    = 8'h50
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [IDX_W-1:0]  cfg_idx,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              io_valid,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_hit,
    input logic              clk_out_en,
    input logic [ADDR_W-1:0] base_q
);
    localparam logic [IDX_W-1:0] IDX_BASE_HI = IDX_BASE_LO + IDX_W'(1);

    logic idx_known;
    assign idx_known = (cfg_idx == IDX_MASK) || (cfg_idx == IDX_BASE_LO) ||
                       (cfg_idx == IDX_BASE_HI) || (cfg_idx == IDX_CTRL);

    AST_MASK_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_idx == IDX_MASK) |=> (cfg_idx != IDX_MASK || cfg_rdata == $past(cfg_wdata))); // R2
    AST_BASE_LO_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_idx == IDX_BASE_LO) |=> (cfg_idx != IDX_BASE_LO || cfg_rdata == $past(cfg_wdata))); // R2
    AST_CTRL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx == IDX_CTRL) |-> (cfg_rdata[DATA_W-1:1] == '0)); // R3
    AST_CLKEN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_idx == IDX_CTRL) |=> (clk_out_en == !$past(cfg_wdata[0]))); // R4
    AST_UNKNOWN_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_known |-> (cfg_rdata == '0)); // R5
    AST_UNKNOWN_WRITE_KEEPS_CLKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !idx_known) |=> $stable(clk_out_en)); // R5
    AST_HIT_HIGH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> (io_addr[ADDR_W-1:MASK_W] == base_q[ADDR_W-1:MASK_W])); // R8
    AST_NO_HIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !io_valid |-> !io_hit); // R9
endmodule

bind io_window_decoder io_win_chk #(
    .IDX_MASK(IDX_MASK), .IDX_BASE_LO(IDX_BASE_LO), .IDX_CTRL(IDX_CTRL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_valid(io_valid),
    .io_addr(io_addr), .io_hit(io_hit), .clk_out_en(clk_out_en),
    .base_q(cfg_q.base)
);

// File: tb/tb_io_window_decoder.sv
// Directed bench for io_window_decoder: one task per scenario, each checking its results.
module tb_io_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_idx = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        io_valid = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic        io_hit;
    logic        clk_out_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench-side model of the programmed window.
    logic [7:0]  m_mask = 8'hFF;
    logic [15:0] m_base = 16'h0000;

    io_window_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_valid(io_valid),
        .io_addr(io_addr), .io_hit(io_hit), .clk_out_en(clk_out_en)
    );

    always #4 clk = ~clk; // 125 MHz

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge; the write lands at the next rising edge.
    task automatic wr(logic [7:0] idx, logic [7:0] d);
        @(negedge clk);
        cfg_idx = idx; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx == 8'h3F) m_mask = d;
        if (idx == 8'h40) m_base[7:0] = d;
        if (idx == 8'h41) m_base[15:8] = d;
    endtask

    task automatic rd_check(string req, logic [7:0] idx, logic [7:0] exp);
        cfg_idx = idx;
        #1;
        check(req, $sformatf("read idx %h", idx), {8'h00, cfg_rdata}, {8'h00, exp});
    endtask

    function automatic logic exp_hit(logic v, logic [15:0] a);
        return v && (((a ^ m_base) & {8'hFF, ~m_mask}) == 16'h0000);
    endfunction

    // Apply an address and check the hit in the same cycle.
    task automatic probe(string req, logic v, logic [15:0] a);
        io_valid = v; io_addr = a;
        #1;
        check(req, $sformatf("hit v=%0b addr=%h", v, a), {15'h0, io_hit}, {15'h0, exp_hit(v, a)});
    endtask

    task automatic t_reset;
        rd_check("R1", 8'h3F, 8'hFF);
        rd_check("R1", 8'h40, 8'h00);
        rd_check("R1", 8'h41, 8'h00);
        rd_check("R1", 8'h50, 8'h00);
        check("R1", "clk_out_en", {15'h0, clk_out_en}, 16'h1);
    endtask

    task automatic t_regs;
        wr(8'h3F, 8'h5A); rd_check("R2", 8'h3F, 8'h5A);
        wr(8'h40, 8'hC3); rd_check("R2", 8'h40, 8'hC3);
        wr(8'h41, 8'h3C); rd_check("R2", 8'h41, 8'h3C);
        rd_check("R2", 8'h3F, 8'h5A);
        wr(8'h40, 8'h80); wr(8'h41, 8'h00);
        rd_check("R2", 8'h40, 8'h80);
        rd_check("R2", 8'h41, 8'h00);
    endtask

    task automatic t_ctrl;
        wr(8'h50, 8'hFF);
        rd_check("R3", 8'h50, 8'h01);
        check("R4", "clk_out_en after disable", {15'h0, clk_out_en}, 16'h0);
        wr(8'h50, 8'hFE);
        rd_check("R3", 8'h50, 8'h00);
        check("R4", "clk_out_en after enable", {15'h0, clk_out_en}, 16'h1);
    endtask

    task automatic t_unimpl;
        wr(8'h3F, 8'h0F); wr(8'h40, 8'h80); wr(8'h41, 8'h12);
        wr(8'h3E, 8'hAA); wr(8'h42, 8'hAA); wr(8'h51, 8'hFF); wr(8'h00, 8'hAA);
        rd_check("R5", 8'h3E, 8'h00);
        rd_check("R5", 8'h42, 8'h00);
        rd_check("R5", 8'h51, 8'h00);
        rd_check("R5", 8'hFF, 8'h00);
        rd_check("R5", 8'h3F, 8'h0F);
        rd_check("R5", 8'h40, 8'h80);
        rd_check("R5", 8'h41, 8'h12);
        check("R5", "clk_out_en unchanged", {15'h0, clk_out_en}, 16'h1);
        probe("R5", 1'b1, 16'h128F);
        check("R5", "hit literal", {15'h0, io_hit}, 16'h1);
    endtask

    task automatic t_match;
        wr(8'h3F, 8'h00); wr(8'h40, 8'h80); wr(8'h41, 8'h00);
        probe("R6", 1'b1, 16'h0080);
        check("R6", "exact hit literal", {15'h0, io_hit}, 16'h1);
        probe("R6", 1'b1, 16'h0081);
        probe("R6", 1'b1, 16'h0000);
        wr(8'h3F, 8'h0F); wr(8'h41, 8'h12);
        probe("R6", 1'b1, 16'h1285);
        probe("R6", 1'b1, 16'h1290);
        check("R6", "unmasked bit4 miss literal", {15'h0, io_hit}, 16'h0);
    endtask

    task automatic t_mask_full;
        wr(8'h40, 8'h00); wr(8'h41, 8'h00); wr(8'h3F, 8'hFF);
        probe("R7", 1'b1, 16'h0000);
        probe("R7", 1'b1, 16'h00FF);
        check("R7", "top of range literal", {15'h0, io_hit}, 16'h1);
        probe("R7", 1'b1, 16'h0055);
        probe("R7", 1'b1, 16'h0100);
        check("R7", "above range literal", {15'h0, io_hit}, 16'h0);
    endtask

    task automatic t_highbyte;
        wr(8'h41, 8'h92); wr(8'h3F, 8'hFF);
        probe("R8", 1'b1, 16'h92C7);
        probe("R8", 1'b1, 16'h93C7);
        probe("R8", 1'b1, 16'h12C7);
        check("R8", "bit15 miss literal", {15'h0, io_hit}, 16'h0);
    endtask

    task automatic t_valid;
        probe("R9", 1'b0, 16'h9200);
        check("R9", "idle literal", {15'h0, io_hit}, 16'h0);
        // Same-cycle response, checked between edges.
        @(negedge clk);
        io_valid = 1'b1; io_addr = 16'h9201;
        #1;
        check("R10", "hit without clock edge", {15'h0, io_hit}, 16'h1);
        io_addr = 16'h0201;
        #1;
        check("R10", "miss without clock edge", {15'h0, io_hit}, 16'h0);
        io_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_ctrl();
        t_unimpl();
        t_match();
        t_mask_full();
        t_highbyte();
        t_valid();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule